// File: doc/BRIEF.md
# Configurable asynchronous frame transmitter

This block turns one parallel character into an asynchronous serial frame on a single line. The line rests high. A frame consists of a low start bit, then the data bits, then an optional parity bit, then one or more high stop bits. Static configuration inputs set the frame shape at run time:
- the character length, from 5 to 8 bits or a 9-bit override;
- the parity kind, which is even, odd, forced low, forced high or none;
- the stop length, which is 1, 1.5 or 2 bits;
- the order of the data bits;
- inversion of the data-bit levels only.

The character enters through a valid/ready handshake. Bit timing comes from an external single-cycle tick, and each bit lasts sixteen ticks.

A client presents a character with `in_valid` while `in_ready` is high. The transmitter takes the character, together with a snapshot of the configuration inputs, on that cycle. It starts the frame at the next tick and holds `busy` high until the last stop tick has passed. Configuration changes made during a frame affect only the following frame.

Top module: `cfg_frame_tx`

## Requirements
- R1: After reset, and at all times while no frame is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: `in_ready` is high only while idle. A character is taken on a cycle where `in_valid` and `in_ready` are both high, and `busy` is high on the next cycle. `in_valid` asserted while busy is ignored.
- R3: The low start bit appears on `txd` the cycle after the first `tick` that follows the accepting cycle. `txd` changes only in the cycle after a `tick`, and every start, data and parity bit spans exactly 16 ticks.
- R4: With `cfg_nine` = 0, `cfg_len` codes 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits, taken from `in_data[n-1:0]`.
- R5: With `cfg_nine` = 1, the frame carries 9 data bits, `in_data[8:0]`, whatever `cfg_len` holds.
- R6: `cfg_par` selects the parity bit that follows the data bits: 0 gives a bit that makes the count of ones in the data plus parity even, 1 makes that count odd, 2 sends 0 and 3 sends 1. Codes 4 to 7 send no parity bit. Parity is computed on the data as supplied, before any inversion.
- R7: `cfg_stop` sets the high stop time: code 0 gives 16 ticks, 1 gives 24 ticks, 2 gives 32 ticks and 3 gives 16 ticks. `txd` is 1 throughout the stop time.
- R8: With `cfg_msb_first` = 0, data bit 0 is sent first. With `cfg_msb_first` = 1, bit n-1 is sent first and bit 0 last.
- R9: With `cfg_invert` = 1, each data bit is sent with its level inverted. The start, parity and stop bits keep their normal levels.
- R10: The data and all configuration inputs are sampled only on the accepting cycle. Changing them during a frame does not alter that frame.
- R11: `busy` falls, and `in_ready` rises, in the cycle after the tick that ends the stop time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle bit-time tick, 16 per bit |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter idle and able to take a character |
| in_data | input | 9 | Character, right-aligned |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_nine | input | 1 | Forces 9 data bits |
| cfg_par | input | 3 | Parity kind code |
| cfg_stop | input | 2 | Stop length code |
| cfg_msb_first | input | 1 | Send the most significant data bit first |
| cfg_invert | input | 1 | Invert the data-bit levels |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The properties assume that `tick` is a clean single-cycle pulse that is sampled on the same clock as the block. They also assume that the line may move only in the cycle after such a pulse, which makes a tick the only event that can advance the frame. The stimulus drives `tick`, the data and the configuration at the falling edge. It accepts a character only from the idle state and drops `in_valid` before the final stop tick, so no handshake overlaps a frame boundary. The sweep runs mostly with a tick on every cycle. Separate frames use a sparse tick and mid-frame changes to the inputs, to exercise the tick gating and the snapshot taken at acceptance.

// File: rtl/cft_pkg.sv
`timescale 1ns/1ps
package cft_pkg;

   // Sequencer phases of one frame.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_SEND = 2'd2,
      ST_STOP = 2'd3
   } cft_state_e;

   // Parity kind codes.
   localparam logic [2:0] PAR_EVEN  = 3'd0;
   localparam logic [2:0] PAR_ODD   = 3'd1;
   localparam logic [2:0] PAR_ZERO  = 3'd2;
   localparam logic [2:0] PAR_ONE   = 3'd3;

   // Stop length codes.
   localparam logic [1:0] STOP_ONE  = 2'd0;
   localparam logic [1:0] STOP_HALF = 2'd1;
   localparam logic [1:0] STOP_TWO  = 2'd2;

endpackage

// File: rtl/cft_framer.sv
`timescale 1ns/1ps
// Combinational frame builder: start bit, ordered and optionally inverted
// data, optional parity, and the index of the last non-stop bit.
module cft_framer
   import cft_pkg::*;
#(
   parameter int DATA_W        = 9,
   parameter int TICKS_PER_BIT = 16,
   parameter int FRAME_W       = DATA_W + 2,
   parameter int IDX_W         = $clog2(FRAME_W),
   parameter int STOP_W        = $clog2(2 * TICKS_PER_BIT + 1)
) (
   input  logic [DATA_W-1:0]  data_i,
   input  logic [1:0]         len_i,
   input  logic               nine_i,
   input  logic [2:0]         par_i,
   input  logic [1:0]         stop_i,
   input  logic               msb_i,
   input  logic               inv_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [IDX_W-1:0]   last_o,
   output logic [STOP_W-1:0]  stop_ticks_o
);

   localparam int MIN_LEN = DATA_W - 4;

   logic [IDX_W-1:0]   ndata;
   logic [DATA_W-1:0]  mask;
   logic [DATA_W-1:0]  ord;
   logic [DATA_W-1:0]  ordi;
   logic [FRAME_W-1:0] fill;
   logic               has_par;
   logic               pbit;

   assign ndata = nine_i ? IDX_W'(DATA_W) : (IDX_W'(MIN_LEN) + IDX_W'(len_i));

   // One slice per data position: in-range mask and bit-order selection.
   for (genvar k = 0; k < DATA_W; k++) begin : g_slot
      logic [IDX_W-1:0] mirror;
      assign mirror  = ndata - IDX_W'(1) - IDX_W'(k);
      assign mask[k] = (IDX_W'(k) < ndata);
      assign ord[k]  = mask[k] & (msb_i ? data_i[mirror] : data_i[k]);
   end

   assign ordi    = ord ^ (mask & {DATA_W{inv_i}});
   assign has_par = (par_i <= PAR_ONE);
   assign fill    = ~((FRAME_W'(1) << (ndata + IDX_W'(1))) - FRAME_W'(1));

   always_comb begin
      unique case (par_i)
         PAR_EVEN: pbit = ^(data_i & mask);
         PAR_ODD:  pbit = ~^(data_i & mask);
         PAR_ZERO: pbit = 1'b0;
         default:  pbit = 1'b1;
      endcase
   end

   always_comb begin
      frame_o = (FRAME_W'(ordi) << 1) | fill;
      if (has_par && !pbit) begin
         frame_o[ndata + IDX_W'(1)] = 1'b0;
      end
   end

   assign last_o = ndata + IDX_W'(has_par);

   always_comb begin
      unique case (stop_i)
         STOP_HALF: stop_ticks_o = STOP_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
         STOP_TWO:  stop_ticks_o = STOP_W'(2 * TICKS_PER_BIT);
         default:   stop_ticks_o = STOP_W'(TICKS_PER_BIT);
      endcase
   end

endmodule

// File: rtl/cft_seq.sv
`timescale 1ns/1ps
// Frame sequencer: captures the built frame on accept and shifts it out
// one bit per TICKS_PER_BIT ticks, followed by the stop time.
module cft_seq
   import cft_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter int FRAME_W       = 11,
   parameter int IDX_W         = $clog2(FRAME_W),
   parameter int STOP_W        = $clog2(2 * TICKS_PER_BIT + 1),
   parameter int TCNT_W        = $clog2(TICKS_PER_BIT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               accept_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [IDX_W-1:0]   last_i,
   input  logic [STOP_W-1:0]  stop_ticks_i,
   output logic               txd_o,
   output cft_state_e         state_o
);

   cft_state_e         st;
   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   last_q;
   logic [STOP_W-1:0]  stop_q;
   logic [IDX_W-1:0]   idx;
   logic [TCNT_W-1:0]  tcnt;
   logic [STOP_W-1:0]  scnt;
   logic               line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         frame_q <= '1;
         last_q  <= '0;
         stop_q  <= '0;
         idx     <= '0;
         tcnt    <= '0;
         scnt    <= '0;
         line    <= 1'b1;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept_i) begin
                  frame_q <= frame_i;
                  last_q  <= last_i;
                  stop_q  <= stop_ticks_i;
                  st      <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (tick_i) begin
                  line <= frame_q[0];
                  idx  <= '0;
                  tcnt <= '0;
                  st   <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (tick_i) begin
                  if (tcnt == TCNT_W'(TICKS_PER_BIT - 1)) begin
                     tcnt <= '0;
                     if (idx == last_q) begin
                        line <= 1'b1;
                        scnt <= '0;
                        st   <= ST_STOP;
                     end else begin
                        idx  <= idx + IDX_W'(1);
                        line <= frame_q[idx + IDX_W'(1)];
                     end
                  end else begin
                     tcnt <= tcnt + TCNT_W'(1);
                  end
               end
            end
            default: begin
               if (tick_i) begin
                  if (scnt == stop_q - STOP_W'(1)) begin
                     st <= ST_IDLE;
                  end else begin
                     scnt <= scnt + STOP_W'(1);
                  end
               end
            end
         endcase
      end
   end

   assign txd_o   = line;
   assign state_o = st;

endmodule

// File: rtl/cfg_frame_tx.sv
`timescale 1ns/1ps
// Configurable asynchronous frame transmitter (top level).
module cfg_frame_tx
   import cft_pkg::*;
#(
   parameter int DATA_W        = 9,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_nine,
   input  logic [2:0]        cfg_par,
   input  logic [1:0]        cfg_stop,
   input  logic              cfg_msb_first,
   input  logic              cfg_invert,
   output logic              txd,
   output logic              busy
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam int STOP_W  = $clog2(2 * TICKS_PER_BIT + 1);
   localparam int TCNT_W  = $clog2(TICKS_PER_BIT);

   // Elaboration-time parameter checks.
   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data_w
      $error("cfg_frame_tx: DATA_W must lie in 5..16");
   end
   if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
      $error("cfg_frame_tx: TICKS_PER_BIT must be even and at least 2");
   end

   logic [FRAME_W-1:0] frame;
   logic [IDX_W-1:0]   last_idx;
   logic [STOP_W-1:0]  stop_ticks;
   logic               accept;
   cft_state_e         state;

   cft_framer #(
      .DATA_W        (DATA_W),
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .FRAME_W       (FRAME_W),
      .IDX_W         (IDX_W),
      .STOP_W        (STOP_W)
   ) i_framer (
      .data_i       (in_data),
      .len_i        (cfg_len),
      .nine_i       (cfg_nine),
      .par_i        (cfg_par),
      .stop_i       (cfg_stop),
      .msb_i        (cfg_msb_first),
      .inv_i        (cfg_invert),
      .frame_o      (frame),
      .last_o       (last_idx),
      .stop_ticks_o (stop_ticks)
   );

   cft_seq #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .FRAME_W       (FRAME_W),
      .IDX_W         (IDX_W),
      .STOP_W        (STOP_W),
      .TCNT_W        (TCNT_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick),
      .accept_i     (accept),
      .frame_i      (frame),
      .last_i       (last_idx),
      .stop_ticks_i (stop_ticks),
      .txd_o        (txd),
      .state_o      (state)
   );

   assign in_ready = (state == ST_IDLE);
   assign busy     = (state != ST_IDLE);
   assign accept   = in_valid & in_ready;

endmodule

// File: rtl/cft_chk.sv
`timescale 1ns/1ps
// Property checker for cfg_frame_tx, attached by bind.
module cft_chk
   import cft_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       in_valid,
   input logic       in_ready,
   input logic       txd,
   input logic       busy,
   input cft_state_e state
);

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R2
   accept_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);

   // R3
   tick_gated_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd));

   // R3
   start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARM && tick) |=> !txd);

   // R7
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP) |-> txd);

   // R11
   finish_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));

endmodule

bind cfg_frame_tx cft_chk i_cft_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .txd      (txd),
   .busy     (busy),
   .state    (state)
);

// File: tb/test_cfg_frame_tx.sv
`timescale 1ns/1ps
module test_cfg_frame_tx;

   localparam int TPB = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [8:0] in_data = '0;
   logic [1:0] cfg_len = '0;
   logic       cfg_nine = 1'b0;
   logic [2:0] cfg_par = 3'd4;
   logic [1:0] cfg_stop = '0;
   logic       cfg_msb_first = 1'b0;
   logic       cfg_invert = 1'b0;
   logic       txd;
   logic       busy;

   int n_chk  = 0;
   int n_fail = 0;
   int n_frame = 0;

   always #5 clk = ~clk;

   cfg_frame_tx #(.DATA_W(9), .TICKS_PER_BIT(TPB)) i_cfg_frame_tx (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_data       (in_data),
      .cfg_len       (cfg_len),
      .cfg_nine      (cfg_nine),
      .cfg_par       (cfg_par),
      .cfg_stop      (cfg_stop),
      .cfg_msb_first (cfg_msb_first),
      .cfg_invert    (cfg_invert),
      .txd           (txd),
      .busy          (busy)
   );

   initial begin
      #1_900_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // Send one frame and compare the line cycle by cycle with a model built
   // from the requirements. tp: tick period in cycles. scr: change inputs
   // and hold in_valid high during the frame.
   task automatic send(input logic [8:0] d, input logic [1:0] len, input logic nine,
                       input logic [2:0] par, input logic [1:0] stop, input logic msb,
                       input logic inv, input int tp, input bit scr, input string tag);
      logic eb [0:10];
      int   nd, nb, st_ticks, total, ones, k, cyc;
      logic prev_tick, e_txd, e_busy, bad;
      nd = nine ? 9 : 5 + int'(len);
      ones = 0;
      eb[0] = 1'b0;
      for (int i = 0; i < nd; i++) begin
         eb[1 + i] = (msb ? d[nd - 1 - i] : d[i]) ^ inv;
         ones += int'(d[i]);
      end
      nb = 1 + nd;
      if (par <= 3'd3) begin
         case (par)
            3'd0:    eb[nb] = (ones % 2) == 1;
            3'd1:    eb[nb] = (ones % 2) == 0;
            3'd2:    eb[nb] = 1'b0;
            default: eb[nb] = 1'b1;
         endcase
         nb++;
      end
      st_ticks = (stop == 2'd1) ? 24 : (stop == 2'd2) ? 32 : 16;
      total = nb * TPB + st_ticks;
      n_frame++;

      @(negedge clk);
      in_data = d; cfg_len = len; cfg_nine = nine; cfg_par = par;
      cfg_stop = stop; cfg_msb_first = msb; cfg_invert = inv;
      in_valid = 1'b1;
      tick = 1'b1;
      @(negedge clk);
      n_chk++;
      if (!(busy === 1'b1 && in_ready === 1'b0 && txd === 1'b1)) begin
         n_fail++;
         $display("FAIL R2 frame %0d accept: busy=%0b ready=%0b txd=%0b expected busy=1 ready=0 txd=1",
                  n_frame, busy, in_ready, txd);
      end
      in_valid = scr;
      if (scr) begin
         in_data = ~d; cfg_len = len + 2'd1; cfg_nine = ~nine; cfg_par = par ^ 3'd3;
         cfg_stop = stop ^ 2'd2; cfg_msb_first = ~msb; cfg_invert = ~inv;
      end
      k = 0;
      cyc = 0;
      bad = 1'b0;
      tick = 1'b1;
      while (k <= total) begin
         prev_tick = tick;
         @(negedge clk);
         if (prev_tick) k++;
         cyc++;
         e_txd  = (k >= 1 && k <= total) ? (((k - 1) < nb * TPB) ? eb[(k - 1) / TPB] : 1'b1) : 1'b1;
         e_busy = (k <= total);
         if (!bad && (txd !== e_txd || busy !== e_busy || in_ready !== !e_busy)) begin
            bad = 1'b1;
            $display("FAIL %s frame %0d tick %0d: txd=%0b busy=%0b ready=%0b expected txd=%0b busy=%0b ready=%0b",
                     tag, n_frame, k, txd, busy, in_ready, e_txd, e_busy, !e_busy);
         end
         if (k == total) in_valid = 1'b0;
         tick = ((cyc % tp) == 0);
      end
      n_chk++;
      if (bad) n_fail++;
      tick = 1'b1;
   endtask

   initial begin
      logic [8:0] pat;
      pat = 9'h0A5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      n_chk++;
      if (!(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1)) begin
         n_fail++;
         $display("FAIL R1 reset: txd=%0b busy=%0b ready=%0b expected txd=1 busy=0 ready=1",
                  txd, busy, in_ready);
      end

      // Sweep of lengths (R4), 9-bit override (R5), parity (R6), stop (R7),
      // bit order (R8), inversion (R9) and end-of-frame timing (R11).
      for (int nine = 0; nine <= 1; nine++) begin
         for (int len = 0; len <= (nine != 0 ? 3 : 3); len += (nine != 0 ? 3 : 1)) begin
            for (int par = 0; par <= 5; par++) begin
               for (int stop = 0; stop <= 3; stop++) begin
                  for (int msb = 0; msb <= 1; msb++) begin
                     for (int inv = 0; inv <= 1; inv++) begin
                        pat = 9'(pat * 9'd5 + 9'd123);
                        send(pat, 2'(len), 1'(nine), 3'(par), 2'(stop), 1'(msb), 1'(inv),
                             1, 1'b0, "R4 R5 R6 R7 R8 R9 R11");
                     end
                  end
               end
            end
         end
      end

      // R3: sparse tick, line moves only after ticks, 16 ticks per bit
      send(9'h15B, 2'd3, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0, 3, 1'b0, "R3");
      send(9'h0C6, 2'd1, 1'b1, 3'd1, 2'd2, 1'b1, 1'b1, 4, 1'b0, "R3");
      // R10 and R2: inputs change and in_valid stays high during the frame
      send(9'h1E3, 2'd2, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 1, 1'b1, "R10 R2");
      send(9'h04D, 2'd0, 1'b1, 3'd2, 2'd1, 1'b1, 1'b0, 2, 1'b1, "R10 R2");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule